// File: doc/BRIEF.md
# Peer Vector Registration Tracker

This block follows a control channel that announces which peers have registered notification vectors with a shared-memory server. The channel arrives one byte per transfer. Every eight accepted bytes form one 64-bit little-endian word. The transfer that carries the last byte of a word also carries a flag, and that flag says whether a handle came with the word. Handles themselves are not modelled. Only their presence decides what the word means.

The block starts in a setup sequence. The first word must be the expected protocol version. The second word is the node's own identifier. After that, peer updates follow until the shared-memory announcement (the value -1) ends setup. Once setup is over, connect and disconnect words keep changing the per-peer vector counts. The block drives a table size, a flattened array of counts, the own identifier, a one-cycle enable pulse when one of the node's own vectors is registered, and sticky error and done flags. Interrupt routing logic uses these to decide which vectors are live.

Top module: `peer_vec_tracker`

## Requirements
- R1: A byte is accepted when `in_valid` and `in_ready` are both high. The first accepted byte becomes bits 7:0 of the word. The eighth accepted byte completes the word, and `in_handle` is sampled with it. `in_ready` is low for exactly the one cycle after the eighth byte is accepted. All effects of the word appear one clock edge after that cycle.
- R2: After reset:
  - `table_size` is 16.
  - All counts are 0.
  - `own_id`, `err`, `setup_done` and `vec_en` are 0.
  - `in_ready` is 1.
- R3: The first word advances setup only if it equals `VERSION` and has no handle. Any other first word sets `err`, and the block keeps waiting for a version word.
- R4: In the identifier stage, a word with no handle and a value from 0 to 65535 is stored in `own_id`, and setup moves on to peer updates. Any other word sets `err`, and the block stays in the identifier stage.
- R5: When `cfg_master` is 1 and the stored identifier is nonzero, `err` is set. The identifier is still stored, and setup still advances.
- R6: After the identifier stage, a word whose signed value is below -1 or above 65535 sets `err` and changes nothing else.
- R7: The word -1 during peer updates raises `setup_done`. The word -1 after `setup_done` is high sets `err`.
- R8: A peer word with a handle increments that peer's count. If the count already equals `NUM_VEC`, the word sets `err` instead and the count is unchanged.
- R9: A peer word without a handle clears that peer's count. If the peer equals `own_id`, the word sets `err` instead and no count is cleared.
- R10: A peer index at or above `table_size` (and below `MAX_PEERS`) first grows `table_size` to index+1. This happens even when the connect or disconnect on the same word then fails. An index at or above `MAX_PEERS` sets `err` and changes neither the size nor any count.
- R11: A successful connect on `own_id` raises `vec_en` for exactly one cycle. `vec_en_idx` equals the peer's count before the increment.
- R12: `err` and `setup_done` stay high until reset once they are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_master | input | 1 | Node is configured as master and must get identifier 0 |
| in_valid | input | 1 | Byte offered |
| in_byte | input | 8 | Byte data |
| in_handle | input | 1 | Handle attached; sampled with the eighth byte |
| in_ready | output | 1 | Byte can be accepted |
| own_id | output | 16 | Node identifier received during setup |
| setup_done | output | 1 | Shared-memory announcement accepted |
| err | output | 1 | Sticky protocol error |
| table_size | output | $clog2(MAX_PEERS+1) | Current number of peer table entries |
| vec_counts | output | MAX_PEERS*CNT_W | Per-peer vector counts; peer i at bits [i*CNT_W +: CNT_W] |
| vec_en | output | 1 | One-cycle pulse for a new own vector |
| vec_en_idx | output | VIDX_W | Index of the newly enabled own vector |

## Verification
Three functions can take effect on the same clock edge, all driven by a single word:
- table growth and a count increment, when a connect names an index beyond the current size;
- table growth and the own-vector pulse, when that connect names `own_id`;
- table growth and a rejected disconnect.

Directed words provoke each of these pairings. For example, a connect to peer 20 while the table holds 16 entries, and connects to the node's own identifier. Random words then mix new indices, handles and invalid values. After every word the bench compares the size, every count, the pulse and the error flag against a model built from the requirements.

// File: rtl/pvt_pkg.sv
package pvt_pkg;
  typedef enum logic [1:0] {ST_VER, ST_ID, ST_PEERS, ST_RUN} stage_e;
  typedef enum logic [1:0] {MK_PEER, MK_SHM, MK_BAD} msg_kind_e;
endpackage

// File: rtl/pvt_assembler.sv
module pvt_assembler #(
  parameter int MSG_BYTES = 8,
  localparam int MW = MSG_BYTES * 8,
  localparam int BCW = $clog2(MSG_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [7:0]    in_byte,
  input  logic          in_handle,
  output logic          in_ready,
  output logic          msg_valid,
  output logic [MW-1:0] msg_value,
  output logic          msg_handle
);
  localparam logic [BCW-1:0] LAST = BCW'(MSG_BYTES - 1);

  logic [BCW-1:0] bcnt_q, bcnt_d;
  logic [MW-1:0]  shr_q, shr_d;
  logic           mv_q, mv_d, mh_q, mh_d;
  logic           take;

  // a full word holds off the next byte for one cycle while it is consumed
  assign in_ready = !mv_q;
  assign take     = in_valid && in_ready;

  always_comb begin
    bcnt_d = bcnt_q;
    shr_d  = shr_q;
    mv_d   = 1'b0;
    mh_d   = mh_q;
    if (take) begin
      shr_d = {in_byte, shr_q[MW-1:8]};
      if (bcnt_q == LAST) begin
        bcnt_d = '0;
        mv_d   = 1'b1;
        mh_d   = in_handle;
      end else begin
        bcnt_d = bcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt_q <= '0;
      shr_q  <= '0;
      mv_q   <= 1'b0;
      mh_q   <= 1'b0;
    end else begin
      bcnt_q <= bcnt_d;
      shr_q  <= shr_d;
      mv_q   <= mv_d;
      mh_q   <= mh_d;
    end
  end

  assign msg_valid  = mv_q;
  assign msg_value  = shr_q;
  assign msg_handle = mh_q;
endmodule

// File: rtl/pvt_classify.sv
module pvt_classify
  import pvt_pkg::*;
(
  input  logic [63:0] msg_value,
  output msg_kind_e   kind,
  output logic [15:0] peer_idx
);
  assign peer_idx = msg_value[15:0];

  always_comb begin
    if (msg_value[63:16] == '0)  kind = MK_PEER;
    else if (&msg_value)         kind = MK_SHM;
    else                         kind = MK_BAD;
  end
endmodule

// File: rtl/pvt_table.sv
module pvt_table #(
  parameter int MAX_PEERS  = 32,
  parameter int INIT_PEERS = 16,
  parameter int NUM_VEC    = 4,
  localparam int IDX_W = (MAX_PEERS > 1) ? $clog2(MAX_PEERS) : 1,
  localparam int SZ_W  = $clog2(MAX_PEERS + 1),
  localparam int CNT_W = $clog2(NUM_VEC + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       grow_en,
  input  logic [SZ_W-1:0]            grow_size,
  input  logic                       inc_en,
  input  logic                       clr_en,
  input  logic [IDX_W-1:0]           op_idx,
  output logic [SZ_W-1:0]            table_size,
  output logic [MAX_PEERS*CNT_W-1:0] counts_flat
);
  logic [SZ_W-1:0] size_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       size_q <= SZ_W'(INIT_PEERS);
    else if (grow_en) size_q <= grow_size;
  end
  assign table_size = size_q;

  for (genvar g = 0; g < MAX_PEERS; g++) begin : g_entry
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             hit;
    assign hit = (op_idx == IDX_W'(g));

    always_comb begin
      cnt_d = cnt_q;
      if (hit && inc_en)      cnt_d = cnt_q + 1'b1;
      else if (hit && clr_en) cnt_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
    end

    assign counts_flat[g*CNT_W +: CNT_W] = cnt_q;
  end
endmodule

// File: rtl/pvt_ctrl.sv
module pvt_ctrl
  import pvt_pkg::*;
#(
  parameter int          MAX_PEERS = 32,
  parameter int          NUM_VEC   = 4,
  parameter logic [63:0] VERSION   = 64'd0,
  localparam int IDX_W  = (MAX_PEERS > 1) ? $clog2(MAX_PEERS) : 1,
  localparam int SZ_W   = $clog2(MAX_PEERS + 1),
  localparam int CNT_W  = $clog2(NUM_VEC + 1),
  localparam int VIDX_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_master,
  input  logic                       msg_valid,
  input  logic [63:0]                msg_value,
  input  logic                       msg_handle,
  input  msg_kind_e                  kind,
  input  logic [15:0]                peer_idx,
  input  logic [SZ_W-1:0]            table_size,
  input  logic [MAX_PEERS*CNT_W-1:0] counts_flat,
  output logic                       grow_en,
  output logic [SZ_W-1:0]            grow_size,
  output logic                       inc_en,
  output logic                       clr_en,
  output logic [IDX_W-1:0]           op_idx,
  output logic [15:0]                own_id,
  output logic                       setup_done,
  output logic                       err,
  output logic                       vec_en,
  output logic [VIDX_W-1:0]          vec_en_idx
);
  localparam logic [15:0]      MAXP16 = 16'(MAX_PEERS);
  localparam logic [CNT_W-1:0] FULL   = CNT_W'(NUM_VEC);

  stage_e            stage_q, stage_d;
  logic [15:0]       own_q, own_d;
  logic              err_q, err_d, done_q, done_d, ven_q, ven_d;
  logic [VIDX_W-1:0] vidx_q, vidx_d;
  logic [CNT_W-1:0]  cur;

  assign op_idx    = peer_idx[IDX_W-1:0];
  assign cur       = counts_flat[op_idx*CNT_W +: CNT_W];
  assign grow_size = SZ_W'(peer_idx) + SZ_W'(1);

  always_comb begin
    stage_d = stage_q;
    own_d   = own_q;
    err_d   = err_q;
    done_d  = done_q;
    ven_d   = 1'b0;
    vidx_d  = vidx_q;
    grow_en = 1'b0;
    inc_en  = 1'b0;
    clr_en  = 1'b0;
    if (msg_valid) begin
      unique case (stage_q)
        ST_VER: begin
          if (msg_value == VERSION && !msg_handle) stage_d = ST_ID;
          else                                     err_d   = 1'b1;
        end
        ST_ID: begin
          if (!msg_handle && kind == MK_PEER) begin
            own_d   = peer_idx;
            stage_d = ST_PEERS;
            if (cfg_master && peer_idx != 16'd0) err_d = 1'b1;
          end else begin
            err_d = 1'b1;
          end
        end
        default: begin
          unique case (kind)
            MK_SHM: begin
              if (stage_q == ST_PEERS) begin
                stage_d = ST_RUN;
                done_d  = 1'b1;
              end else begin
                err_d = 1'b1;
              end
            end
            MK_PEER: begin
              if (peer_idx >= MAXP16) begin
                err_d = 1'b1;
              end else begin
                grow_en = (peer_idx >= 16'(table_size));
                if (msg_handle) begin
                  if (cur == FULL) begin
                    err_d = 1'b1;
                  end else begin
                    inc_en = 1'b1;
                    if (peer_idx == own_q) begin
                      ven_d  = 1'b1;
                      vidx_d = cur[VIDX_W-1:0];
                    end
                  end
                end else if (peer_idx == own_q) begin
                  err_d = 1'b1;
                end else begin
                  clr_en = 1'b1;
                end
              end
            end
            default: err_d = 1'b1;
          endcase
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= ST_VER;
      own_q   <= '0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
      ven_q   <= 1'b0;
      vidx_q  <= '0;
    end else begin
      stage_q <= stage_d;
      own_q   <= own_d;
      err_q   <= err_d;
      done_q  <= done_d;
      ven_q   <= ven_d;
      vidx_q  <= vidx_d;
    end
  end

  assign own_id     = own_q;
  assign setup_done = done_q;
  assign err        = err_q;
  assign vec_en     = ven_q;
  assign vec_en_idx = vidx_q;
endmodule

// File: rtl/peer_vec_tracker.sv
module peer_vec_tracker
  import pvt_pkg::*;
#(
  parameter int          MAX_PEERS  = 32,
  parameter int          INIT_PEERS = 16,
  parameter int          NUM_VEC    = 4,
  parameter logic [63:0] VERSION    = 64'd0,
  localparam int IDX_W  = (MAX_PEERS > 1) ? $clog2(MAX_PEERS) : 1,
  localparam int SZ_W   = $clog2(MAX_PEERS + 1),
  localparam int CNT_W  = $clog2(NUM_VEC + 1),
  localparam int VIDX_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_master,
  input  logic                       in_valid,
  input  logic [7:0]                 in_byte,
  input  logic                       in_handle,
  output logic                       in_ready,
  output logic [15:0]                own_id,
  output logic                       setup_done,
  output logic                       err,
  output logic [SZ_W-1:0]            table_size,
  output logic [MAX_PEERS*CNT_W-1:0] vec_counts,
  output logic                       vec_en,
  output logic [VIDX_W-1:0]          vec_en_idx
);
  logic             msg_valid, msg_handle;
  logic [63:0]      msg_value;
  msg_kind_e        kind;
  logic [15:0]      peer_idx;
  logic             grow_en, inc_en, clr_en;
  logic [SZ_W-1:0]  grow_size;
  logic [IDX_W-1:0] op_idx;

  pvt_assembler #(.MSG_BYTES(8)) u_asm (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .in_handle(in_handle), .in_ready(in_ready), .msg_valid(msg_valid),
    .msg_value(msg_value), .msg_handle(msg_handle)
  );

  pvt_classify u_cls (.msg_value(msg_value), .kind(kind), .peer_idx(peer_idx));

  pvt_table #(.MAX_PEERS(MAX_PEERS), .INIT_PEERS(INIT_PEERS), .NUM_VEC(NUM_VEC)) u_tab (
    .clk(clk), .rst_n(rst_n), .grow_en(grow_en), .grow_size(grow_size),
    .inc_en(inc_en), .clr_en(clr_en), .op_idx(op_idx),
    .table_size(table_size), .counts_flat(vec_counts)
  );

  pvt_ctrl #(.MAX_PEERS(MAX_PEERS), .NUM_VEC(NUM_VEC), .VERSION(VERSION)) u_ctl (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .msg_valid(msg_valid),
    .msg_value(msg_value), .msg_handle(msg_handle), .kind(kind),
    .peer_idx(peer_idx), .table_size(table_size), .counts_flat(vec_counts),
    .grow_en(grow_en), .grow_size(grow_size), .inc_en(inc_en), .clr_en(clr_en),
    .op_idx(op_idx), .own_id(own_id), .setup_done(setup_done), .err(err),
    .vec_en(vec_en), .vec_en_idx(vec_en_idx)
  );
endmodule

// File: rtl/pvt_checker.sv
module pvt_checker #(
  parameter int MAX_PEERS  = 32,
  parameter int INIT_PEERS = 16,
  parameter int NUM_VEC    = 4,
  localparam int SZ_W   = $clog2(MAX_PEERS + 1),
  localparam int CNT_W  = $clog2(NUM_VEC + 1),
  localparam int VIDX_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [15:0]                own_id,
  input logic                       setup_done,
  input logic                       err,
  input logic [SZ_W-1:0]            table_size,
  input logic [MAX_PEERS*CNT_W-1:0] vec_counts,
  input logic                       vec_en,
  input logic [VIDX_W-1:0]          vec_en_idx
);
  p_err_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  p_done_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    setup_done |=> setup_done);
  p_own_id_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    setup_done |=> $stable(own_id));
  p_size_grow_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> table_size >= $past(table_size));
  p_size_bounds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(table_size) >= INIT_PEERS) && (32'(table_size) <= MAX_PEERS));
  p_vec_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    vec_en |=> !vec_en);
  p_vec_idx_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
    vec_en |-> (32'(vec_en_idx) < NUM_VEC));

  for (genvar g = 0; g < MAX_PEERS; g++) begin : g_cnt
    p_count_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      32'(vec_counts[g*CNT_W +: CNT_W]) <= NUM_VEC);
  end
endmodule

bind peer_vec_tracker pvt_checker #(
  .MAX_PEERS(MAX_PEERS), .INIT_PEERS(INIT_PEERS), .NUM_VEC(NUM_VEC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .own_id(own_id), .setup_done(setup_done), .err(err),
  .table_size(table_size), .vec_counts(vec_counts), .vec_en(vec_en),
  .vec_en_idx(vec_en_idx)
);

// File: tb/peer_vec_tracker_tb.sv
module peer_vec_tracker_tb;
  localparam int MAXP = 32;
  localparam int INIT = 16;
  localparam int NV   = 4;
  localparam int CW   = 3;
  localparam int SZW  = 6;
  localparam int VW   = 2;
  localparam logic [63:0] VER  = 64'd0;
  localparam logic [63:0] SHM  = 64'hFFFF_FFFF_FFFF_FFFF;

  logic clk, rst_n, cfg_master, in_valid, in_handle, in_ready;
  logic [7:0] in_byte;
  logic [15:0] own_id;
  logic setup_done, err, vec_en;
  logic [SZW-1:0] table_size;
  logic [MAXP*CW-1:0] vec_counts;
  logic [VW-1:0] vec_en_idx;

  int checks, errors;

  // expected state
  int m_stage, m_own, m_size, m_vidx;
  bit m_err, m_done, m_ven;
  int m_cnt [MAXP];

  peer_vec_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .in_valid(in_valid),
    .in_byte(in_byte), .in_handle(in_handle), .in_ready(in_ready),
    .own_id(own_id), .setup_done(setup_done), .err(err),
    .table_size(table_size), .vec_counts(vec_counts), .vec_en(vec_en),
    .vec_en_idx(vec_en_idx)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_stage = 0; m_own = 0; m_size = INIT; m_err = 0; m_done = 0; m_ven = 0; m_vidx = 0;
    for (int i = 0; i < MAXP; i++) m_cnt[i] = 0;
  endtask

  task automatic model_apply(input logic [63:0] v, input bit h);
    int p;
    m_ven = 0;
    if (m_stage == 0) begin
      if (v == VER && !h) m_stage = 1; else m_err = 1;
    end else if (m_stage == 1) begin
      if (!h && v[63:16] == 0) begin
        m_own = int'(v[15:0]); m_stage = 2;
        if (cfg_master && m_own != 0) m_err = 1;
      end else m_err = 1;
    end else if (v == SHM) begin
      if (m_stage == 2) begin m_stage = 3; m_done = 1; end else m_err = 1;
    end else if (v[63:16] != 0) begin
      m_err = 1;
    end else begin
      p = int'(v[15:0]);
      if (p >= MAXP) m_err = 1;
      else begin
        if (p >= m_size) m_size = p + 1;
        if (h) begin
          if (m_cnt[p] == NV) m_err = 1;
          else begin
            if (p == m_own) begin m_ven = 1; m_vidx = m_cnt[p]; end
            m_cnt[p]++;
          end
        end else if (p == m_own) m_err = 1;
        else m_cnt[p] = 0;
      end
    end
  endtask

  task automatic compare(input string tag);
    int bad;
    bad = -1;
    for (int i = 0; i < MAXP; i++)
      if (bad < 0 && int'(vec_counts[i*CW +: CW]) != m_cnt[i]) bad = i;
    if (bad >= 0) chk(tag, $sformatf("count[%0d]", bad), vec_counts[bad*CW +: CW], m_cnt[bad]);
    else chk(tag, "counts", 0, 0);
    chk(tag, "table_size", table_size, m_size);
    chk(tag, "err", err, m_err);
    chk(tag, "setup_done", setup_done, m_done);
    chk(tag, "own_id", own_id, m_own);
    chk(tag, "vec_en", vec_en, m_ven);
    if (m_ven) chk(tag, "vec_en_idx", vec_en_idx, m_vidx);
  endtask

  task automatic send(input logic [63:0] v, input bit h, input string tag, input bit gaps);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (gaps && ($urandom % 4 == 0)) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      while (!in_ready) @(negedge clk);
      in_valid  = 1'b1;
      in_byte   = v[i*8 +: 8];
      in_handle = (i == 7) ? h : 1'b0;
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk("R1", "in_ready bubble", in_ready, 0);
    @(posedge clk);
    @(negedge clk);
    model_apply(v, h);
    compare(tag);
  endtask

  task automatic do_reset(input bit master);
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; in_byte = '0; in_handle = 1'b0; cfg_master = master;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    @(negedge clk);
  endtask

  task automatic setup(input int id);
    send(VER, 0, "R3", 0);
    send(64'(id), 0, "R4", 0);
    send(SHM, 0, "R7", 0);
  endtask

  initial begin
    checks = 0; errors = 0;
    void'($urandom(32'd20240607));
    rst_n = 1'b0; cfg_master = 1'b0; in_valid = 1'b0; in_byte = '0; in_handle = 1'b0;

    // reset state
    do_reset(0);
    chk("R2", "in_ready", in_ready, 1);
    compare("R2");
    send(64'd5, 0, "R3", 0);                  // wrong version
    send(VER, 1, "R3", 0);                    // right value but handle

    do_reset(1);
    send(VER, 0, "R3", 0);
    send(64'd3, 0, "R5", 0);                  // master with nonzero id

    do_reset(1);
    send(VER, 0, "R3", 0);
    send(64'd0, 0, "R5", 0);                  // master with id 0 is fine

    do_reset(0);
    send(VER, 0, "R3", 0);
    send(64'd2, 1, "R4", 0);                  // id with handle
    send(64'h1_0000, 0, "R4", 0);             // id out of range

    // main flow with growth and own-vector pulses
    do_reset(0);
    send(VER, 0, "R3", 1);
    send(64'h0000_0000_0000_0102, 0, "R1", 1); // own id 258: bytes in order
    do_reset(0);
    send(VER, 0, "R3", 1);
    send(64'd2, 0, "R4", 1);
    send(64'd0, 1, "R8", 1);
    send(64'd2, 1, "R11", 0);
    send(64'd2, 1, "R11", 0);
    send(64'd20, 1, "R10", 0);                // growth + connect on same word
    send(64'd0, 0, "R9", 0);                  // clear
    send(SHM, 0, "R7", 0);
    send(64'd25, 0, "R10", 0);                // growth + clear after setup

    do_reset(0);
    setup(1);
    for (int k = 0; k < NV; k++) send(64'd5, 1, "R8", 0);
    send(64'd5, 1, "R8", 0);                  // full
    send(64'd6, 1, "R12", 0);                 // err remains set
    do_reset(0);
    setup(1);
    send(64'd22, 1, "R10", 0);
    do_reset(0);
    setup(22);
    send(64'd22, 0, "R9", 0);                 // own disconnect: growth, then error
    do_reset(0);
    setup(1);
    send(64'h1_0000, 0, "R6", 0);
    do_reset(0);
    setup(1);
    send(64'hFFFF_FFFF_FFFF_FFFE, 1, "R6", 0); // -2
    do_reset(0);
    setup(1);
    send(SHM, 0, "R7", 0);                    // second announcement
    do_reset(0);
    setup(1);
    send(64'd40, 1, "R10", 0);                // beyond max depth
    send(64'd31, 1, "R10", 0);                // last legal entry

    // random phase
    do_reset(0);
    send(VER, 0, "R3", 0);
    send(64'd3, 0, "R4", 0);
    for (int n = 0; n < 400; n++) begin
      int r;
      logic [63:0] v;
      bit h;
      r = int'($urandom % 100);
      h = ($urandom % 3) != 0;
      if (r < 80) v = 64'($urandom % 40);
      else if (r < 86) v = SHM;
      else if (r < 93) v = 64'h1_0000 + 64'($urandom % 1000);
      else v = ~64'(1 + ($urandom % 5));      // -2 .. -6
      send(v, h, (r < 80) ? (h ? "R8" : "R9") : "R6", 1);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule